// File: doc/BRIEF.md
# AES Key Expansion Assist Unit

This unit performs a single helper step of AES-128 key expansion. It takes a 128-bit source word, an 8-bit round constant, a flag that selects the legacy or the extended instruction encoding, and a 4-bit reserved field. It returns a 128-bit packed result that software or a sequencer combines with the previous round key. The result holds the byte-substituted forms of source lanes 1 and 3, and also the rotated and round-constant-mixed forms of the same two lanes.

The unit also produces the bits of a wider destination register above bit 127. In legacy mode it passes through the old value supplied on the input. In extended mode with a correct encoding it clears those bits. When the extended encoding carries a bad reserved field, the unit raises a flag and suppresses the write.

Operands enter through a valid/ready handshake. The result is held until the consumer takes it. The number of S-box instances is a parameter: with fewer instances, the eight byte substitutions are spread over several cycles.

Top module: `aeska_keyassist`

## Requirements
- R1: The source splits into four 32-bit lanes, with lane 0 at bits 31:0, lane 1 at 63:32, lane 2 at 95:64 and lane 3 at 127:96. Result bits 31:0 equal the byte-wise S-box substitution of lane 1.
- R2: Result bits 63:32 equal the rotation of the substituted lane 1, XORed with the round constant zero-extended to 32 bits. For an input word with bytes {b3,b2,b1,b0}, from most to least significant, the rotation gives {b0,b3,b2,b1}.
- R3: Result bits 95:64 equal the byte-wise S-box substitution of lane 3.
- R4: Result bits 127:96 equal the rotated substituted lane 3, XORed with the zero-extended round constant.
- R5: Source lanes 0 and 2 have no effect on any output.
- R6: The substitution is the standard AES forward S-box. It is the GF(2^8) inverse under polynomial 0x11B, followed by the AES affine map, and it maps 0x00 to 0x63.
- R7: When in_ext_mode is 0 (legacy mode), out_upper equals the in_upper value captured with the operand, out_write_en is 1, and the reserved field is ignored.
- R8: When in_ext_mode is 1 and in_rsv is 4'b1111, out_upper is all zeros and out_write_en is 1.
- R9: When in_ext_mode is 1 and in_rsv is any value other than 4'b1111, the held output has out_bad_enc equal to 1, out_write_en equal to 0, out_result equal to zero, and out_upper equal to the captured in_upper.
- R10: An operand is accepted on a rising edge where in_valid and in_ready are both high. in_ready stays low from acceptance until the result is taken. While out_valid is high and out_ready is low, out_valid and all result outputs stay stable. After out_ready is seen, out_valid falls and in_ready rises.
- R11: While reset is held, and on the first cycle after it, in_ready is 1 and out_valid is 0.
- R12: For the AES-128 key 2b7e151628aed2a6abf7158809cf4f3c, loaded with memory byte 0 at bits 7:0, and round constant 0x01, result bits 127:96 equal 32'h01eb848b. XORing them with lane 0 gives the first word of round key 1, a0 fa fe 17 in memory order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can accept an operand |
| in_src | input | 128 | Source word, four 32-bit lanes |
| in_rcon | input | 8 | Round constant byte |
| in_ext_mode | input | 1 | 1 selects the extended encoding, 0 legacy |
| in_rsv | input | 4 | Reserved register-specifier field |
| in_upper | input | UPPER_W | Previous destination bits above 127 |
| out_valid | output | 1 | Result held and valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Packed assist result |
| out_upper | output | UPPER_W | New destination bits above 127 |
| out_write_en | output | 1 | Destination write is allowed |
| out_bad_enc | output | 1 | Invalid-encoding flag |

## Verification
The bench compares against an S-box it builds by brute-force search for each inverse. It checks input 0x00 separately, because a design that inverts zero wrongly or drops the 0x63 constant fails only there. It changes lanes 0 and 2 while keeping lanes 1 and 3 fixed: a lane-select error that picks the even lanes changes the result. The known key-schedule vector catches a rotation in the wrong direction or a round constant XORed into the wrong byte. Reserved-field values other than 1111b in extended mode, and any value in legacy mode, expose a check that is missing or applied in the wrong mode. Random stalls on out_ready catch outputs that drift or a second operand that is accepted while a result is still held.

// File: rtl/aeska_pkg.sv
// Package: shared types and GF(2^8) arithmetic for the key assist unit.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package aeska_pkg;

    typedef logic [7:0]  byte_t;
    typedef logic [31:0] word_t;

    localparam int SRC_W   = 128;
    localparam int LANE_W  = 32;
    localparam int NBYTES  = 8;    // bytes of lanes 1 and 3 that get substituted

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } st_t;

    // Multiply two field elements (shift-and-add with reduction).
    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t x;
        acc = '0;
        x   = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254; maps 0 to 0.
    function automatic byte_t gf_inv(byte_t a);
        byte_t sq;
        byte_t r;
        sq = a;
        r  = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

endpackage

// File: rtl/aeska_sbox.sv
// Module: one AES forward S-box, purely combinational.
// Computes the field inverse and then the affine map; no table storage.
module aeska_sbox
    import aeska_pkg::*;
(
    input  logic [7:0] in_byte,
    output logic [7:0] out_byte
);

    byte_t inv_b;

    // Field inverse followed by the affine transform with constant 0x63.
    always_comb begin
        inv_b    = gf_inv(in_byte);
        out_byte = inv_b
                 ^ {inv_b[6:0], inv_b[7]}
                 ^ {inv_b[5:0], inv_b[7:6]}
                 ^ {inv_b[4:0], inv_b[7:5]}
                 ^ {inv_b[3:0], inv_b[7:4]}
                 ^ 8'h63;
    end

endmodule

// File: rtl/aeska_sub_engine.sv
// Module: substitutes NB_IN bytes using SBOX_COUNT S-boxes over
// NB_IN/SBOX_COUNT cycles. Assumes SBOX_COUNT divides NB_IN and that
// src_bytes stays stable from start until finishing.
module aeska_sub_engine
    import aeska_pkg::*;
#(
    parameter int SBOX_COUNT = 8,
    parameter int NB_IN      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NB_IN*8-1:0]   src_bytes,
    output logic                 finishing,
    output logic [NB_IN*8-1:0]   sub_bytes
);

    localparam int GROUPS = NB_IN / SBOX_COUNT;
    localparam int CNT_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam logic [CNT_W-1:0] LAST_GRP = CNT_W'(GROUPS - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    assign finishing = run_q && (cnt_q == LAST_GRP);

    // Group counter: starts at 0 on start, stops after the last group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (finishing) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < SBOX_COUNT; i++) begin : g_sb
        byte_t sb_in;
        byte_t sb_out;

        // Pick the byte of the current group that feeds this S-box.
        always_comb begin
            sb_in = '0;
            for (int g = 0; g < GROUPS; g++) begin
                if (cnt_q == CNT_W'(g)) sb_in = src_bytes[(g*SBOX_COUNT + i)*8 +: 8];
            end
        end

        aeska_sbox u_sbox (
            .in_byte  (sb_in),
            .out_byte (sb_out)
        );
    end

    for (genvar j = 0; j < NB_IN; j++) begin : g_slot
        byte_t slot_q;

        // Capture this byte's substitution during its group's cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (run_q && (cnt_q == CNT_W'(j / SBOX_COUNT)))
                slot_q <= g_sb[j % SBOX_COUNT].sb_out;
        end

        assign sub_bytes[j*8 +: 8] = slot_q;
    end

endmodule

// File: rtl/aeska_assemble.sv
// Module: builds the 128-bit packed result from two substituted lanes
// and the round constant. Combinational; rotation moves byte 0 to the top.
module aeska_assemble
    import aeska_pkg::*;
(
    input  logic [31:0]  sub_lo,   // substituted lane 1
    input  logic [31:0]  sub_hi,   // substituted lane 3
    input  logic [7:0]   rcon,
    output logic [127:0] result
);

    function automatic word_t rot_byte(word_t w);
        return {w[7:0], w[31:8]};
    endfunction

    word_t rc_word;

    // Zero-extend the constant and place the four result lanes.
    always_comb begin
        rc_word = {24'h0, rcon};
        result  = {rot_byte(sub_hi) ^ rc_word,
                   sub_hi,
                   rot_byte(sub_lo) ^ rc_word,
                   sub_lo};
    end

endmodule

// File: rtl/aeska_enc_check.sv
// Module: flags a bad reserved field in the extended encoding.
// Legacy mode never flags.
module aeska_enc_check #(
    parameter int          RSV_W  = 4,
    parameter logic [RSV_W-1:0] RSV_OK = '1
) (
    input  logic             ext_mode,
    input  logic [RSV_W-1:0] rsv,
    output logic             bad
);

    // Bad only when the extended form carries a non-all-ones field.
    always_comb bad = ext_mode && (rsv != RSV_OK);

endmodule

// File: rtl/aeska_keyassist.sv
// Module: top of the AES key expansion assist unit. Accepts one operand
// per handshake, runs the substitution engine, holds the packed result
// until out_ready. Assumes in_upper carries the destination's old bits.
module aeska_keyassist
    import aeska_pkg::*;
#(
    parameter int DEST_W     = 256,
    parameter int SBOX_COUNT = 8,
    parameter int RSV_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [127:0]          in_src,
    input  logic [7:0]            in_rcon,
    input  logic                  in_ext_mode,
    input  logic [RSV_W-1:0]      in_rsv,
    input  logic [DEST_W-129:0]   in_upper,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [127:0]          out_result,
    output logic [DEST_W-129:0]   out_upper,
    output logic                  out_write_en,
    output logic                  out_bad_enc
);

    localparam int UPPER_W = DEST_W - SRC_W;
    localparam int SUB_W   = NBYTES * 8;

    st_t                st_q;
    logic [SUB_W-1:0]   lanes_q;     // {lane 3, lane 1}
    logic [7:0]         rcon_q;
    logic               ext_q;
    logic               bad_q;
    logic [UPPER_W-1:0] upper_q;

    logic               accept;
    logic               bad_now;
    logic               finishing;
    logic [SUB_W-1:0]   sub_bytes;
    logic [127:0]       packed_res;

    assign in_ready  = (st_q == ST_IDLE);
    assign out_valid = (st_q == ST_HOLD);
    assign accept    = in_valid && in_ready;

    aeska_enc_check #(.RSV_W(RSV_W)) u_chk_enc (
        .ext_mode (in_ext_mode),
        .rsv      (in_rsv),
        .bad      (bad_now)
    );

    // Handshake state: idle -> busy on accept, busy -> hold, hold -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (accept)    st_q <= ST_BUSY;
                ST_BUSY: if (finishing) st_q <= ST_HOLD;
                ST_HOLD: if (out_ready) st_q <= ST_IDLE;
                default:                st_q <= ST_IDLE;
            endcase
        end
    end

    // Operand capture; only lanes 1 and 3 are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_q <= '0;
            rcon_q  <= '0;
            ext_q   <= 1'b0;
            bad_q   <= 1'b0;
            upper_q <= '0;
        end else if (accept) begin
            lanes_q <= {in_src[127:96], in_src[63:32]};
            rcon_q  <= in_rcon;
            ext_q   <= in_ext_mode;
            bad_q   <= bad_now;
            upper_q <= in_upper;
        end
    end

    aeska_sub_engine #(
        .SBOX_COUNT (SBOX_COUNT),
        .NB_IN      (NBYTES)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .src_bytes (lanes_q),
        .finishing (finishing),
        .sub_bytes (sub_bytes)
    );

    aeska_assemble u_asm (
        .sub_lo (sub_bytes[31:0]),
        .sub_hi (sub_bytes[63:32]),
        .rcon   (rcon_q),
        .result (packed_res)
    );

    // Output shaping: mask on bad encoding, clear upper bits in extended mode.
    always_comb begin
        out_result   = bad_q ? '0 : packed_res;
        out_upper    = (ext_q && !bad_q) ? '0 : upper_q;
        out_write_en = out_valid && !bad_q;
        out_bad_enc  = out_valid && bad_q;
    end

endmodule

// File: rtl/aeska_checker.sv
// Module: protocol and output-shape properties for aeska_keyassist,
// attached by bind. Observes ports plus the captured mode bit.
module aeska_checker #(
    parameter int UPPER_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [127:0]       out_result,
    input logic [UPPER_W-1:0] out_upper,
    input logic               out_write_en,
    input logic               out_bad_enc,
    input logic               ext_q
);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_upper)
                                    && $stable(out_write_en) && $stable(out_bad_enc));

    // R10
    single_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R10
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready);

    // R9
    bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad_enc |-> !out_write_en && (out_result == '0));

    // R8
    ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_write_en && ext_q |-> (out_upper == '0));

    // R11
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> in_ready && !out_valid);

endmodule

bind aeska_keyassist aeska_checker #(.UPPER_W(DEST_W - 128)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_result   (out_result),
    .out_upper    (out_upper),
    .out_write_en (out_write_en),
    .out_bad_enc  (out_bad_enc),
    .ext_q        (ext_q)
);

// File: tb/sim_aeska_keyassist.sv
`timescale 1ns/1ps
module sim_aeska_keyassist;

    localparam int UPPER_W = 128;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [127:0]       in_src = '0;
    logic [7:0]         in_rcon = '0;
    logic               in_ext_mode = 1'b0;
    logic [3:0]         in_rsv = '0;
    logic [UPPER_W-1:0] in_upper = '0;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic [127:0]       out_result;
    logic [UPPER_W-1:0] out_upper;
    logic               out_write_en;
    logic               out_bad_enc;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] ref_sb [256];

    always #4 clk = ~clk;   // 125 MHz

    aeska_keyassist #(.DEST_W(256), .SBOX_COUNT(8), .RSV_W(4)) u0 (.*);

    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] iv = 0;
            logic [7:0] s;
            for (int c = 1; c < 256; c++)
                if (ref_mul(8'(v), 8'(c)) == 8'h01) iv = 8'(c);
            s = iv ^ {iv[6:0], iv[7]} ^ {iv[5:0], iv[7:6]} ^ {iv[4:0], iv[7:5]}
                   ^ {iv[3:0], iv[7:4]} ^ 8'h63;
            ref_sb[v] = s;
        end
    endtask

    function automatic logic [31:0] ref_sub(logic [31:0] w);
        return {ref_sb[w[31:24]], ref_sb[w[23:16]], ref_sb[w[15:8]], ref_sb[w[7:0]]};
    endfunction

    function automatic logic [31:0] ref_rot(logic [31:0] w);
        return {w[7:0], w[31:24], w[23:16], w[15:8]};
    endfunction

    function automatic logic [127:0] ref_res(logic [127:0] s, logic [7:0] rc);
        logic [31:0] a = ref_sub(s[63:32]);
        logic [31:0] b = ref_sub(s[127:96]);
        return {ref_rot(b) ^ {24'h0, rc}, b, ref_rot(a) ^ {24'h0, rc}, a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [127:0] s, input logic [7:0] rc, input logic ext,
                         input logic [3:0] rsv, input logic [UPPER_W-1:0] up, input int hold,
                         output logic [127:0] r, output logic [UPPER_W-1:0] u,
                         output logic we, output logic bd);
        int guard;
        @(negedge clk);
        in_src = s; in_rcon = rc; in_ext_mode = ext; in_rsv = rsv; in_upper = up;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_src = ~s; in_upper = ~up;    // disturb inputs after acceptance
        guard = 0;
        while (!out_valid && guard < 50) begin @(negedge clk); guard++; end
        check(out_valid, "R10", "out_valid after accept", 128'(out_valid), 128'd1);
        r = out_result; u = out_upper; we = out_write_en; bd = out_bad_enc;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(out_valid && !in_ready && out_result == r && out_upper == u,
                  "R10", "held output stable", out_result, r);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R10", "release", {out_valid, in_ready}, 128'b01);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] r, r2, s, key;
        logic [UPPER_W-1:0] u, up;
        logic we, bd, ext, bad_exp;
        logic [3:0] rsv;
        logic [7:0] rc;
        int unsigned seed_v = 32'hC0FFEE11;
        void'($urandom(seed_v));
        build_sbox();

        // R11: reset state while held and just after release
        repeat (3) @(negedge clk);
        check(in_ready && !out_valid, "R11", "during reset", {in_ready, out_valid}, 128'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid, "R11", "after reset", {in_ready, out_valid}, 128'b10);

        // R6: all-zero source gives 0x63 bytes
        do_op('0, 8'h00, 1'b0, 4'h0, '0, 0, r, u, we, bd);
        check(r == {32'h63636363, 32'h63636363, 32'h63636363, 32'h63636363},
              "R6", "zero source", r, {4{32'h63636363}});

        // R12: known key-schedule vector, memory byte 0 at bits 7:0
        key = {32'h3c4fcf09, 32'h8815f7ab, 32'ha6d2ae28, 32'h16157e2b};
        do_op(key, 8'h01, 1'b0, 4'h0, '0, 1, r, u, we, bd);
        check(r[127:96] == 32'h01eb848b, "R12", "lane3 mix", r[127:96], 32'h01eb848b);
        check((r[127:96] ^ key[31:0]) == 32'h17fefaa0, "R12", "round key word",
              r[127:96] ^ key[31:0], 32'h17fefaa0);
        check(r[95:64] == 32'heb848a01, "R3", "lane3 sub on vector", r[95:64], 32'heb848a01);

        // R5: vary lanes 0 and 2 only
        s = {$urandom, $urandom, $urandom, $urandom};
        do_op(s, 8'h36, 1'b0, 4'h3, '0, 0, r, u, we, bd);
        s[31:0] = ~s[31:0]; s[95:64] = s[95:64] ^ 32'h5a5a5a5a;
        do_op(s, 8'h36, 1'b0, 4'h3, '0, 2, r2, u, we, bd);
        check(r == r2, "R5", "even lanes ignored", r2, r);

        // R7: legacy keeps upper bits, reserved field ignored
        up = {$urandom, $urandom, $urandom, $urandom};
        do_op(s, 8'h1b, 1'b0, 4'h0, up, 0, r, u, we, bd);
        check(u == up && we && !bd, "R7", "legacy upper", u, up);
        check(r == ref_res(s, 8'h1b), "R7", "legacy result with rsv 0", r, ref_res(s, 8'h1b));

        // R8: extended, good field clears upper
        do_op(s, 8'h80, 1'b1, 4'hF, up, 1, r, u, we, bd);
        check(u == '0 && we && !bd, "R8", "ext upper cleared", u, '0);

        // R9: extended, bad field
        do_op(s, 8'h80, 1'b1, 4'hE, up, 1, r, u, we, bd);
        check(bd && !we && r == '0 && u == up, "R9", "bad encoding", {bd, we, r[125:0]}, 128'b10 << 126);

        // R1-type random sweep with mixed modes and stalls
        for (int n = 0; n < 300; n++) begin
            s   = {$urandom, $urandom, $urandom, $urandom};
            rc  = 8'($urandom);
            ext = 1'($urandom);
            rsv = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            up  = {$urandom, $urandom, $urandom, $urandom};
            bad_exp = ext && (rsv != 4'hF);
            do_op(s, rc, ext, rsv, up, int'($urandom % 4), r, u, we, bd);
            if (bad_exp) begin
                check(bd && !we && r == '0, "R9", "random bad", r, '0);
                check(u == up, "R9", "random bad upper", u, up);
            end else begin
                check(r[31:0] == ref_sub(s[63:32]), "R1", "lane1 sub", r[31:0], ref_sub(s[63:32]));
                check(r[63:32] == (ref_rot(ref_sub(s[63:32])) ^ {24'h0, rc}), "R2", "lane1 mix",
                      r[63:32], ref_rot(ref_sub(s[63:32])) ^ {24'h0, rc});
                check(r[95:64] == ref_sub(s[127:96]), "R3", "lane3 sub", r[95:64], ref_sub(s[127:96]));
                check(r[127:96] == (ref_rot(ref_sub(s[127:96])) ^ {24'h0, rc}), "R4", "lane3 mix",
                      r[127:96], ref_rot(ref_sub(s[127:96])) ^ {24'h0, rc});
                if (ext) check(u == '0 && we, "R8", "random ext upper", u, '0);
                else     check(u == up && we, "R7", "random legacy upper", u, up);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule